// File: doc/BRIEF.md
# Bounds Configuration and Status Unit

This unit keeps two registers for a processor core that checks pointer bounds: the supervisor bounds-configuration register, which holds an enable bit (bit 0), a preserve bit (bit 1), reserved bits 11:2 and a base linear address in the upper bits, and the bounds-status register. Events from the core modify the configuration register. A system-management entry strobe places the current value on a save port, tagged with its fixed state-save offset, and then zeroes the register. A system-management resume strobe reloads the register from a saved image. On that path the reserved field is zeroed and the address is made canonical. A virtual-machine exit may zero the register and a virtual-machine entry may load it from a guest-state bus, each under its own control bit. Software may also write the register.

The unit also decides whether bounds checking is active for the current privilege level. At level 3 it uses the user configuration enable, and at levels 0 to 2 it uses the supervisor register enable. In both cases three extended-state enable inputs must also be set. When the core reports a range fault raised by a bound-check instruction while checking is active, the status register is zeroed. Software may also write the status register.

Top module: `bcs_unit`

## Requirements
- R1: After reset the configuration register and the status register both read zero.
- R2: In the cycle mgmt_enter is high, save_valid is high, save_addr is 16'h7ED0 and save_data equals the configuration register. From the next cycle the configuration register is zero.
- R3: A resume loads the configuration register from resume_data. Bits 1:0 and 47:12 are copied unchanged, bits 11:2 become zero, and bits 63:48 each take the value of resume_data bit 47.
- R4: A VM exit with vmexit_clr set zeroes the configuration register. A VM exit with vmexit_clr clear leaves it unchanged.
- R5: A VM entry with vmentry_ld set loads guest_cfg unchanged into the configuration register. A VM entry with vmentry_ld clear leaves it unchanged.
- R6: When several configuration events are high in one cycle, only the highest-ranked one acts. The ranking is mgmt_enter, then mgmt_resume, then vm_exit, then vm_entry, then the software write. A VM exit or VM entry takes its rank even when its control bit is clear.
- R7: A software write to the configuration register takes effect only when bits 11:2 of the write data are zero. Otherwise the register is unchanged.
- R8: chk_enabled is high exactly when os_xsave_en, st_bnd_en and st_cfg_en are all high and the selected enable is high. The selected enable is user_cfg_en when cpl is 3 and bit 0 of the configuration register otherwise.
- R9: A bound fault while chk_enabled is high zeroes the status register in the next cycle. A bound fault while chk_enabled is low leaves it unchanged.
- R10: A software status write loads the status register. If an enabled bound fault occurs in the same cycle, the fault wins and the status becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_enter | input | 1 | System-management entry strobe |
| mgmt_resume | input | 1 | System-management resume strobe |
| resume_data | input | 64 | Saved configuration image used on resume |
| vm_exit | input | 1 | VM exit strobe |
| vmexit_clr | input | 1 | VM exit control: zero the configuration register |
| vm_entry | input | 1 | VM entry strobe |
| vmentry_ld | input | 1 | VM entry control: load from the guest-state bus |
| guest_cfg | input | 64 | Guest-state configuration value |
| sw_cfg_we | input | 1 | Software write strobe for the configuration register |
| sw_cfg_wdata | input | 64 | Software write data for the configuration register |
| cpl | input | 2 | Current privilege level |
| os_xsave_en | input | 1 | Operating-system extended-save enable |
| st_bnd_en | input | 1 | Bound-register state enable |
| st_cfg_en | input | 1 | Bound-configuration state enable |
| user_cfg_en | input | 1 | Enable bit of the user configuration register |
| bound_fault | input | 1 | Range fault raised by a bound-check instruction |
| sw_st_we | input | 1 | Software write strobe for the status register |
| sw_st_wdata | input | 64 | Software write data for the status register |
| sup_cfg | output | 64 | Supervisor configuration register |
| status | output | 64 | Bounds-status register |
| chk_enabled | output | 1 | Bounds checking active at the current privilege level |
| save_valid | output | 1 | Save port carries a value to store |
| save_addr | output | 16 | State-save offset for the saved value |
| save_data | output | 64 | Configuration value to be saved |

## Verification
Two functions can act in the same cycle. A bound fault can arrive together with a system-management entry or a VM exit that zeroes the configuration register. The bench raises both strobes at once with checking enabled through the supervisor bit at a privilege level below 3. Checking must then be judged on the configuration value from before the clear, so the status is expected to be zero while the configuration also becomes zero. A scoreboard model, written from the requirements, predicts both registers one cycle ahead. It also covers the other collisions: entry against resume, resume against VM exit, VM entry against a software write, and fault against a status write.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    SRC_HOLD   = 3'd0,
    SRC_CLEAR  = 3'd1,
    SRC_RESUME = 3'd2,
    SRC_GUEST  = 3'd3,
    SRC_SW     = 3'd4
  } cfg_src_e;

endpackage

// File: rtl/bcs_cfg_sel.sv
module bcs_cfg_sel
  import bcs_pkg::*;
#(
  parameter int RSVD_W = 10
) (
  input  logic              mgmt_enter,
  input  logic              mgmt_resume,
  input  logic              vm_exit,
  input  logic              vmexit_clr,
  input  logic              vm_entry,
  input  logic              vmentry_ld,
  input  logic              sw_we,
  input  logic [RSVD_W-1:0] sw_rsvd,
  output cfg_src_e          src
);

  logic sw_legal;

  assign sw_legal = (sw_rsvd == '0);

  always_comb begin
    src = SRC_HOLD;
    if (mgmt_enter) begin
      src = SRC_CLEAR;
    end else if (mgmt_resume) begin
      src = SRC_RESUME;
    end else if (vm_exit) begin
      src = vmexit_clr ? SRC_CLEAR : SRC_HOLD;
    end else if (vm_entry) begin
      src = vmentry_ld ? SRC_GUEST : SRC_HOLD;
    end else if (sw_we && sw_legal) begin
      src = SRC_SW;
    end
  end

endmodule

// File: rtl/bcs_cfg_reg.sv
module bcs_cfg_reg
  import bcs_pkg::*;
#(
  parameter int REG_W   = 64,
  parameter int LA_W    = 48,
  parameter int RSVD_LO = 2,
  parameter int RSVD_HI = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_src_e         src,
  input  logic [REG_W-1:0] resume_data,
  input  logic [REG_W-1:0] guest_data,
  input  logic [REG_W-1:0] sw_data,
  output logic [REG_W-1:0] cfg_q
);

  localparam int EXT_W = REG_W - LA_W + 1;

  logic [REG_W-1:0] san;
  logic [REG_W-1:0] cfg_d;
  logic             cfg_en;

  for (genvar b = 0; b < REG_W; b++) begin : g_san
    if (b >= RSVD_LO && b <= RSVD_HI) begin : g_rsvd
      assign san[b] = resume_data[b] & 1'b0;
    end else if (b >= LA_W) begin : g_ext
      assign san[b] = resume_data[LA_W-1] | (resume_data[b] & 1'b0);
    end else begin : g_keep
      assign san[b] = resume_data[b];
    end
  end

  always_comb begin
    cfg_d  = cfg_q;
    cfg_en = 1'b0;
    unique case (src)
      SRC_CLEAR:  begin cfg_d = '0;         cfg_en = 1'b1; end
      SRC_RESUME: begin cfg_d = san;        cfg_en = 1'b1; end
      SRC_GUEST:  begin cfg_d = guest_data; cfg_en = 1'b1; end
      SRC_SW:     begin cfg_d = sw_data;    cfg_en = 1'b1; end
      default:    begin cfg_d = cfg_q;      cfg_en = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  AST_RESUME_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_RESUME) |=> (cfg_q[RSVD_HI:RSVD_LO] == '0)); // R3
  AST_RESUME_CANONICAL: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_RESUME) |=> ((&cfg_q[REG_W-1:LA_W-1]) || (cfg_q[REG_W-1:LA_W-1] == {EXT_W{1'b0}}))); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_HOLD) |=> $stable(cfg_q)); // R6

endmodule

// File: rtl/bcs_enable.sv
module bcs_enable (
  input  logic [1:0] cpl,
  input  logic       os_xsave_en,
  input  logic       st_bnd_en,
  input  logic       st_cfg_en,
  input  logic       user_en,
  input  logic       sup_en,
  output logic       enabled
);

  logic sel_en;

  assign sel_en  = (cpl == 2'd3) ? user_en : sup_en;
  assign enabled = os_xsave_en & st_bnd_en & st_cfg_en & sel_en;

endmodule

// File: rtl/bcs_status_reg.sv
module bcs_status_reg #(
  parameter int ST_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fault,
  input  logic            enabled,
  input  logic            sw_we,
  input  logic [ST_W-1:0] sw_data,
  output logic [ST_W-1:0] st_q
);

  logic [ST_W-1:0] st_d;
  logic            st_en;

  always_comb begin
    st_d  = st_q;
    st_en = 1'b0;
    if (fault && enabled) begin
      st_d  = '0;
      st_en = 1'b1;
    end else if (sw_we) begin
      st_d  = sw_data;
      st_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  AST_FAULT_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && enabled) |=> (st_q == '0)); // R9
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && !(fault && enabled)) |=> $stable(st_q)); // R9

endmodule

// File: rtl/bcs_unit.sv
module bcs_unit
  import bcs_pkg::*;
#(
  parameter int          REG_W    = 64,
  parameter int          LA_W     = 48,
  parameter int          RSVD_LO  = 2,
  parameter int          RSVD_HI  = 11,
  parameter int          SAVE_AW  = 16,
  parameter logic [15:0] SAVE_OFS = 16'h7ED0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mgmt_enter,
  input  logic               mgmt_resume,
  input  logic [REG_W-1:0]   resume_data,
  input  logic               vm_exit,
  input  logic               vmexit_clr,
  input  logic               vm_entry,
  input  logic               vmentry_ld,
  input  logic [REG_W-1:0]   guest_cfg,
  input  logic               sw_cfg_we,
  input  logic [REG_W-1:0]   sw_cfg_wdata,
  input  logic [1:0]         cpl,
  input  logic               os_xsave_en,
  input  logic               st_bnd_en,
  input  logic               st_cfg_en,
  input  logic               user_cfg_en,
  input  logic               bound_fault,
  input  logic               sw_st_we,
  input  logic [REG_W-1:0]   sw_st_wdata,
  output logic [REG_W-1:0]   sup_cfg,
  output logic [REG_W-1:0]   status,
  output logic               chk_enabled,
  output logic               save_valid,
  output logic [SAVE_AW-1:0] save_addr,
  output logic [REG_W-1:0]   save_data
);

  localparam int RSVD_W = RSVD_HI - RSVD_LO + 1;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  cfg_src_e   cfg_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  bcs_cfg_sel #(.RSVD_W(RSVD_W)) u_sel (
    .mgmt_enter  (mgmt_enter),
    .mgmt_resume (mgmt_resume),
    .vm_exit     (vm_exit),
    .vmexit_clr  (vmexit_clr),
    .vm_entry    (vm_entry),
    .vmentry_ld  (vmentry_ld),
    .sw_we       (sw_cfg_we),
    .sw_rsvd     (sw_cfg_wdata[RSVD_HI:RSVD_LO]),
    .src         (cfg_src)
  );

  bcs_cfg_reg #(.REG_W(REG_W), .LA_W(LA_W), .RSVD_LO(RSVD_LO), .RSVD_HI(RSVD_HI)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .src         (cfg_src),
    .resume_data (resume_data),
    .guest_data  (guest_cfg),
    .sw_data     (sw_cfg_wdata),
    .cfg_q       (sup_cfg)
  );

  bcs_enable u_en (
    .cpl         (cpl),
    .os_xsave_en (os_xsave_en),
    .st_bnd_en   (st_bnd_en),
    .st_cfg_en   (st_cfg_en),
    .user_en     (user_cfg_en),
    .sup_en      (sup_cfg[0]),
    .enabled     (chk_enabled)
  );

  bcs_status_reg #(.ST_W(REG_W)) u_st (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .fault   (bound_fault),
    .enabled (chk_enabled),
    .sw_we   (sw_st_we),
    .sw_data (sw_st_wdata),
    .st_q    (status)
  );

  assign save_valid = mgmt_enter;
  assign save_addr  = SAVE_OFS[SAVE_AW-1:0];
  assign save_data  = sup_cfg;

  AST_ENTER_CLEARS: assert property (@(posedge clk) disable iff (!rst_core_n)
    mgmt_enter |=> (sup_cfg == '0)); // R2
  AST_VMEXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (vm_exit && vmexit_clr && !mgmt_enter && !mgmt_resume) |=> (sup_cfg == '0)); // R4
  AST_SW_REJECT: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sw_cfg_we && (sw_cfg_wdata[RSVD_HI:RSVD_LO] != '0) && !mgmt_enter && !mgmt_resume
     && !vm_exit && !vm_entry) |=> $stable(sup_cfg)); // R7
  AST_USER_GATE: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((cpl == 2'd3) && !user_cfg_en) |-> !chk_enabled); // R8

endmodule

// File: tb/bcs_unit_tb.sv
module bcs_unit_tb;

  typedef struct {
    logic [63:0] cfg;
    logic [63:0] st;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mgmt_enter, mgmt_resume, vm_exit, vmexit_clr, vm_entry, vmentry_ld;
  logic [63:0] resume_data, guest_cfg, sw_cfg_wdata, sw_st_wdata;
  logic        sw_cfg_we, os_xsave_en, st_bnd_en, st_cfg_en, user_cfg_en;
  logic        bound_fault, sw_st_we;
  logic [1:0]  cpl;
  logic [63:0] sup_cfg, status, save_data;
  logic        chk_enabled, save_valid;
  logic [15:0] save_addr;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];
  logic [63:0] m_cfg, m_st;

  always #5 clk = ~clk;

  bcs_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mgmt_enter(mgmt_enter), .mgmt_resume(mgmt_resume),
    .resume_data(resume_data), .vm_exit(vm_exit), .vmexit_clr(vmexit_clr),
    .vm_entry(vm_entry), .vmentry_ld(vmentry_ld), .guest_cfg(guest_cfg),
    .sw_cfg_we(sw_cfg_we), .sw_cfg_wdata(sw_cfg_wdata), .cpl(cpl),
    .os_xsave_en(os_xsave_en), .st_bnd_en(st_bnd_en), .st_cfg_en(st_cfg_en),
    .user_cfg_en(user_cfg_en), .bound_fault(bound_fault), .sw_st_we(sw_st_we),
    .sw_st_wdata(sw_st_wdata), .sup_cfg(sup_cfg), .status(status),
    .chk_enabled(chk_enabled), .save_valid(save_valid), .save_addr(save_addr),
    .save_data(save_data)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] san(input logic [63:0] d);
    return {{16{d[47]}}, d[47:12], 10'b0, d[1:0]};
  endfunction

  task automatic clear_strobes();
    mgmt_enter = 0; mgmt_resume = 0; vm_exit = 0; vmexit_clr = 0;
    vm_entry = 0; vmentry_ld = 0; sw_cfg_we = 0; bound_fault = 0; sw_st_we = 0;
  endtask

  // Driver: called at a negedge with inputs set; predicts and pushes, then advances.
  task automatic cycle(input string tag);
    logic       en;
    logic [63:0] nc, ns;
    exp_t       it;
    #1;
    en = os_xsave_en & st_bnd_en & st_cfg_en & ((cpl == 2'd3) ? user_cfg_en : m_cfg[0]);
    check({"R8 ", tag}, {63'd0, chk_enabled}, {63'd0, en});
    if (mgmt_enter) begin
      check("R2 save_valid", {63'd0, save_valid}, 64'd1);
      check("R2 save_addr", {48'd0, save_addr}, 64'h7ED0);
      check("R2 save_data", save_data, m_cfg);
    end
    nc = m_cfg;
    if (mgmt_enter) nc = '0;
    else if (mgmt_resume) nc = san(resume_data);
    else if (vm_exit) nc = vmexit_clr ? 64'd0 : m_cfg;
    else if (vm_entry) nc = vmentry_ld ? guest_cfg : m_cfg;
    else if (sw_cfg_we && sw_cfg_wdata[11:2] == 10'd0) nc = sw_cfg_wdata;
    ns = m_st;
    if (bound_fault && en) ns = '0;
    else if (sw_st_we) ns = sw_st_wdata;
    m_cfg = nc; m_st = ns;
    it.cfg = nc; it.st = ns; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    clear_strobes();
  endtask

  // Monitor: compares the registers after each active edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        check({it.tag, " cfg"}, sup_cfg, it.cfg);
        check({it.tag, " status"}, status, it.st);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 act=hung exp=done");
      finish_run();
    end
  end

  initial begin
    clear_strobes();
    resume_data = '0; guest_cfg = '0; sw_cfg_wdata = '0; sw_st_wdata = '0;
    cpl = 2'd0; os_xsave_en = 1; st_bnd_en = 1; st_cfg_en = 1; user_cfg_en = 0;
    m_cfg = '0; m_st = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 cfg reset", sup_cfg, 64'd0);
    check("R1 status reset", status, 64'd0);

    sw_st_we = 1; sw_st_wdata = 64'hDEAD_BEEF_0000_1234; cycle("R10 status write");
    sw_cfg_we = 1; sw_cfg_wdata = 64'h0000_7FFF_FFFF_F003; cycle("R7 legal write");
    sw_cfg_we = 1; sw_cfg_wdata = 64'h0000_1234_5678_0004; cycle("R7 rejected write");
    bound_fault = 1; cycle("R9 fault enabled supervisor");
    sw_st_we = 1; sw_st_wdata = 64'h55; cycle("R10 status write again");
    cpl = 2'd3; user_cfg_en = 0; bound_fault = 1; cycle("R9 fault disabled user");
    user_cfg_en = 1; bound_fault = 1; sw_st_we = 1; sw_st_wdata = 64'h77; cycle("R10 fault beats write");
    cpl = 2'd1; os_xsave_en = 0; sw_st_we = 1; sw_st_wdata = 64'h99; cycle("R10 write");
    bound_fault = 1; cycle("R9 fault without os enable");
    os_xsave_en = 1; st_cfg_en = 0; bound_fault = 1; cycle("R9 fault without cfg state");
    st_cfg_en = 1;
    mgmt_enter = 1; bound_fault = 1; cycle("R2 enter with fault");
    mgmt_resume = 1; resume_data = 64'h1234_8000_0000_5FFF; cycle("R3 resume sign ext one");
    mgmt_resume = 1; resume_data = 64'hFFFF_7ABC_DEF0_1FFE; cycle("R3 resume sign ext zero");
    mgmt_enter = 1; mgmt_resume = 1; resume_data = 64'h3; cycle("R6 enter over resume");
    mgmt_resume = 1; resume_data = 64'h0000_0000_0001_0001; vm_exit = 1; vmexit_clr = 1; cycle("R6 resume over exit");
    vm_exit = 1; vmexit_clr = 0; cycle("R4 exit without clear");
    vm_exit = 1; vmexit_clr = 1; cycle("R4 exit with clear");
    vm_entry = 1; vmentry_ld = 1; guest_cfg = 64'hABCD_0000_0000_0FF1; cycle("R5 entry load");
    vm_entry = 1; vmentry_ld = 0; guest_cfg = 64'h1; cycle("R5 entry no load");
    vm_entry = 1; vmentry_ld = 0; sw_cfg_we = 1; sw_cfg_wdata = 64'h2; cycle("R6 entry blocks write");
    vm_exit = 1; vmexit_clr = 0; vm_entry = 1; vmentry_ld = 1; guest_cfg = 64'h3; cycle("R6 exit blocks entry");
    sw_cfg_we = 1; sw_cfg_wdata = 64'h0000_0000_0000_1001; cycle("R7 enable via write");
    cpl = 2'd0; sw_st_we = 1; sw_st_wdata = 64'hF0; cycle("R8 sup enabled");
    vm_exit = 1; vmexit_clr = 1; bound_fault = 1; cycle("R9 fault with exit clear");
    bound_fault = 1; sw_st_we = 1; sw_st_wdata = 64'h11; cycle("R9 fault after clear disabled");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule